// File: doc/BRIEF.md
# I/Q Sample Pattern Checker

This block watches a stream of 16-bit I/Q sample pairs and compares each pair with a known test pattern of four programmed words. The words form two pairs, pair 0 (I0 with Q0) and pair 1 (I1 with Q1). The stream is expected to alternate between the two pairs. Any difference raises a sticky compare-fail flag. Two per-bit masks, one for I and one for Q, collect every bit position that has differed since the last clear. An interrupt line can optionally follow the fail flag.

Software programs the block through a byte-wide write port. Pattern word `w` lives at byte addresses `2w` (low byte) and `2w+1` (high byte), with word order I0=0, Q0=1, I1=2, Q1=3. Writing address 8 sets the control bits: bit 0 turns detection on and bit 1 routes the fail flag to the interrupt. Writing any data to address 9 clears the fail flag and both masks.

A frame marker that arrives with a valid sample forces that sample to be compared against pair 0. Right after detection is switched on, the alignment of the stream is unknown, so software clears the status once after enabling.

Top module: `iq_pattern_checker`

## Requirements
- R1: After reset the fail flag, both masks and the interrupt are 0, and detection and interrupt routing are off.
- R2: A write to address 2w loads bits 7:0 of pattern word w, and a write to 2w+1 loads bits 15:8 (w: 0=I0, 1=Q0, 2=I1, 3=Q1). Samples equal to the programmed words never raise the fail flag.
- R3: When no frame marker is present, each valid sample is compared against the pair opposite to the previous valid sample's pair. This holds whether or not the previous sample matched.
- R4: A valid sample that carries the frame marker is compared against pair 0, and the next valid sample is compared against pair 1.
- R5: While detection is off, the phase is held at pair 0, so the first valid sample after enabling is compared against pair 0.
- R6: Each mask bit is set one cycle after a valid, enabled sample whose bit differs from the expected word. Mask bits stay set until a clear, so they hold the OR of every difference seen.
- R7: The fail flag is set one cycle after any enabled mismatch and stays set until a clear.
- R8: While detection is off (control bit 0 = 0), samples change neither the flag nor the masks.
- R9: A write to address 9 clears the flag and both masks at the next edge. If a mismatch is seen in that same cycle, only that mismatch is recorded.
- R10: The interrupt is a level equal to the fail flag ANDed with control bit 1.
- R11: Cycles with the valid strobe low do not advance the phase and record nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| smp_valid | input | 1 | Sample pair valid |
| smp_frame | input | 1 | Frame marker: this sample aligns to pair 0 |
| smp_i | input | 16 | I sample |
| smp_q | input | 16 | Q sample |
| cmp_fail | output | 1 | Sticky compare-fail flag |
| err_mask_i | output | 16 | Sticky per-bit error mask for I |
| err_mask_q | output | 16 | Sticky per-bit error mask for Q |
| irq | output | 1 | Level interrupt |

## Verification
The stream is tried in several forms, and each one separates a different fault:
- An in-order stream of both pairs shows that the bytes were assembled correctly.
- Pair-1 data placed in a pair-0 slot shows that the phase really alternates, because the masks then equal I0^I1 and Q0^Q1.
- Frame markers placed in the odd slot and re-enabling after a disabled stretch show the realignment rules.
- Single-bit errors on different bits show that the masks accumulate.
- A clear that coincides with a mismatch shows the priority rule.

A long random stream then runs alongside a bench model. It mixes bit flips, gaps in the valid strobe, frame markers, clears and control changes.

// File: rtl/iqpc_pkg.sv
package iqpc_pkg;
    localparam int SAMPLE_W   = 16;
    localparam int BYTE_W     = 8;
    localparam int NUM_WORDS  = 4;
    localparam int LANES      = SAMPLE_W / BYTE_W;
    localparam int CTRL_ADDR  = NUM_WORDS * LANES;
    localparam int CLR_ADDR   = CTRL_ADDR + 1;
    localparam int CFG_ADDR_W = $clog2(CLR_ADDR + 1);

    typedef enum logic {
        PAIR0 = 1'b0,
        PAIR1 = 1'b1
    } pair_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] i;
        logic [SAMPLE_W-1:0] q;
    } iq_t;

    typedef struct packed {
        logic irq_en;
        logic det_en;
    } ctrl_t;

    function automatic pair_e other_pair(input pair_e p);
        return (p == PAIR0) ? PAIR1 : PAIR0;
    endfunction

    function automatic logic any_bit(input iq_t v);
        return |{v.i, v.q};
    endfunction
endpackage

// File: rtl/iqpc_cfg_regs.sv
module iqpc_cfg_regs
    import iqpc_pkg::*;
#(
    parameter int DATA_W = SAMPLE_W,
    parameter int ADDR_W = CFG_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BYTE_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] pat_word [NUM_WORDS],
    output ctrl_t             ctrl,
    output logic              clr_pulse
);
    localparam int NLANE = DATA_W / BYTE_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                pat_word[w] <= '0;
            end
            ctrl <= '0;
        end else if (cfg_wr) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                for (int b = 0; b < NLANE; b++) begin
                    if (cfg_addr == ADDR_W'(w * NLANE + b)) begin
                        pat_word[w][b*BYTE_W +: BYTE_W] <= cfg_wdata;
                    end
                end
            end
            if (cfg_addr == ADDR_W'(CTRL_ADDR)) begin
                ctrl.det_en <= cfg_wdata[0];
                ctrl.irq_en <= cfg_wdata[1];
            end
        end
    end

    assign clr_pulse = cfg_wr && (cfg_addr == ADDR_W'(CLR_ADDR));
endmodule

// File: rtl/iqpc_phase.sv
module iqpc_phase
    import iqpc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  det_en,
    input  logic  smp_valid,
    input  logic  smp_frame,
    output pair_e cur_pair
);
    pair_e phase_q;

    // A frame marker overrides the running phase for this sample.
    assign cur_pair = smp_frame ? PAIR0 : phase_q;

    always_ff @(posedge clk) begin
        if (rst || !det_en) begin
            phase_q <= PAIR0;
        end else if (smp_valid) begin
            phase_q <= other_pair(cur_pair);
        end
    end
endmodule

// File: rtl/iqpc_compare.sv
module iqpc_compare
    import iqpc_pkg::*;
#(
    parameter int DATA_W = SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              det_en,
    input  logic              clr,
    input  logic              smp_valid,
    input  iq_t               smp,
    input  iq_t               expect_iq,
    output logic [DATA_W-1:0] err_i,
    output logic [DATA_W-1:0] err_q,
    output logic              fail
);
    iq_t  diff;
    logic hit;

    assign hit    = smp_valid && det_en;
    assign diff.i = hit ? (smp.i ^ expect_iq.i) : '0;
    assign diff.q = hit ? (smp.q ^ expect_iq.q) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_i <= '0;
            err_q <= '0;
            fail  <= 1'b0;
        end else if (clr) begin
            // A mismatch in the clearing cycle survives the clear.
            err_i <= diff.i;
            err_q <= diff.q;
            fail  <= any_bit(diff);
        end else begin
            err_i <= err_i | diff.i;
            err_q <= err_q | diff.q;
            fail  <= fail | any_bit(diff);
        end
    end
endmodule

// File: rtl/iq_pattern_checker.sv
module iq_pattern_checker
    import iqpc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_wr,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [BYTE_W-1:0]     cfg_wdata,
    input  logic                  smp_valid,
    input  logic                  smp_frame,
    input  logic [SAMPLE_W-1:0]   smp_i,
    input  logic [SAMPLE_W-1:0]   smp_q,
    output logic                  cmp_fail,
    output logic [SAMPLE_W-1:0]   err_mask_i,
    output logic [SAMPLE_W-1:0]   err_mask_q,
    output logic                  irq
);
    logic [SAMPLE_W-1:0] pat_word [NUM_WORDS];
    ctrl_t ctrl;
    logic  clr_pulse;
    pair_e cur_pair;
    iq_t   smp;
    iq_t   pair_word [2];
    iq_t   expect_iq;

    iqpc_cfg_regs #(.DATA_W(SAMPLE_W), .ADDR_W(CFG_ADDR_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .pat_word  (pat_word),
        .ctrl      (ctrl),
        .clr_pulse (clr_pulse)
    );

    iqpc_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .det_en    (ctrl.det_en),
        .smp_valid (smp_valid),
        .smp_frame (smp_frame),
        .cur_pair  (cur_pair)
    );

    // Word order is I then Q inside each pair.
    for (genvar p = 0; p < 2; p++) begin : g_pair
        assign pair_word[p].i = pat_word[2*p];
        assign pair_word[p].q = pat_word[2*p+1];
    end

    assign expect_iq = (cur_pair == PAIR0) ? pair_word[0] : pair_word[1];
    assign smp.i     = smp_i;
    assign smp.q     = smp_q;

    iqpc_compare #(.DATA_W(SAMPLE_W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .det_en    (ctrl.det_en),
        .clr       (clr_pulse),
        .smp_valid (smp_valid),
        .smp       (smp),
        .expect_iq (expect_iq),
        .err_i     (err_mask_i),
        .err_q     (err_mask_q),
        .fail      (cmp_fail)
    );

    assign irq = cmp_fail && ctrl.irq_en;
endmodule

// File: rtl/iqpc_chk.sv
module iqpc_chk
    import iqpc_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                det_en,
    input logic                irq_en,
    input logic                clr,
    input logic                smp_valid,
    input logic                fail,
    input logic [SAMPLE_W-1:0] err_i,
    input logic [SAMPLE_W-1:0] err_q,
    input logic                irq
);
    // R1
    reset_clean_chk: assert property (@(posedge clk)
        rst |=> (!fail && err_i == '0 && err_q == '0 && !irq));

    // R6
    mask_grows_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (((err_i & $past(err_i)) == $past(err_i)) &&
                  ((err_q & $past(err_q)) == $past(err_q))));

    // R7
    fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (fail && !clr) |=> fail);

    // R7
    mask_implies_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (err_i != '0 || err_q != '0) |-> fail);

    // R8
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!det_en && !clr) |=> ($stable(err_i) && $stable(err_q) && $stable(fail)));

    // R9
    clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !(smp_valid && det_en)) |=> (!fail && err_i == '0 && err_q == '0));

    // R10
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (fail && irq_en) |-> irq);

    // R10
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && !clr) |=> ($stable(err_i) && $stable(err_q) && $stable(fail)));
endmodule

bind iq_pattern_checker iqpc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .det_en    (ctrl.det_en),
    .irq_en    (ctrl.irq_en),
    .clr       (clr_pulse),
    .smp_valid (smp_valid),
    .fail      (cmp_fail),
    .err_i     (err_mask_i),
    .err_q     (err_mask_q),
    .irq       (irq)
);

// File: tb/iq_pattern_checker_tb.sv
module iq_pattern_checker_tb;
    import iqpc_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [3:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic        smp_valid;
    logic        smp_frame;
    logic [15:0] smp_i;
    logic [15:0] smp_q;
    logic        cmp_fail;
    logic [15:0] err_mask_i;
    logic [15:0] err_mask_q;
    logic        irq;

    always #10 clk = ~clk;

    iq_pattern_checker u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .smp_valid(smp_valid), .smp_frame(smp_frame),
        .smp_i(smp_i), .smp_q(smp_q), .cmp_fail(cmp_fail),
        .err_mask_i(err_mask_i), .err_mask_q(err_mask_q), .irq(irq)
    );

    // Bench model built from the requirements
    logic [15:0] m_pat [4];
    logic        m_en, m_irqen, m_fail, m_ph;
    logic [15:0] m_ei, m_eq;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;

    function automatic logic [15:0] exp_i(input logic p);
        return p ? m_pat[2] : m_pat[0];
    endfunction

    function automatic logic [15:0] exp_q(input logic p);
        return p ? m_pat[3] : m_pat[1];
    endfunction

    task automatic check(input string tag);
        logic eirq;
        eirq = m_fail && m_irqen;
        checks++;
        if (cmp_fail !== m_fail || err_mask_i !== m_ei || err_mask_q !== m_eq || irq !== eirq) begin
            fails++;
            $display("FAIL %s: got fail=%0b mi=%h mq=%h irq=%0b, expected fail=%0b mi=%h mq=%h irq=%0b",
                     tag, cmp_fail, err_mask_i, err_mask_q, irq, m_fail, m_ei, m_eq, eirq);
        end
    endtask

    // Called at a falling edge: drive, update model, cross one rising edge, check at next falling edge.
    task automatic cyc(input logic wr, input logic [3:0] a, input logic [7:0] d,
                       input logic v, input logic f, input logic [15:0] si,
                       input logic [15:0] sq, input string tag);
        logic        clr, hit, p;
        logic [15:0] di, dq;
        cfg_wr = wr; cfg_addr = a; cfg_wdata = d;
        smp_valid = v; smp_frame = f; smp_i = si; smp_q = sq;
        clr = wr && (a == 4'd9);
        hit = v && m_en;
        p   = f ? 1'b0 : m_ph;
        di  = hit ? (si ^ exp_i(p)) : 16'h0;
        dq  = hit ? (sq ^ exp_q(p)) : 16'h0;
        if (clr) begin
            m_ei = di; m_eq = dq; m_fail = |{di, dq};
        end else begin
            m_ei = m_ei | di; m_eq = m_eq | dq; m_fail = m_fail | (|{di, dq});
        end
        if (!m_en) m_ph = 1'b0;
        else if (v) m_ph = ~p;
        if (wr && a < 4'd8) m_pat[a[2:1]][a[0]*8 +: 8] = d;
        if (wr && a == 4'd8) begin
            m_en = d[0]; m_irqen = d[1];
        end
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
        cyc(1'b1, a, d, 1'b0, 1'b0, 16'h0, 16'h0, tag);
    endtask

    task automatic smp(input logic f, input logic [15:0] si, input logic [15:0] sq, input string tag);
        cyc(1'b0, 4'd0, 8'd0, 1'b1, f, si, sq, tag);
    endtask

    task automatic send_pair(input logic p, input logic f, input string tag);
        smp(f, exp_i(p), exp_q(p), tag);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        smp_valid = 1'b0; smp_frame = 1'b0; smp_i = '0; smp_q = '0;
        for (int k = 0; k < 4; k++) m_pat[k] = 16'h0;
        m_en = 0; m_irqen = 0; m_fail = 0; m_ph = 0; m_ei = 0; m_eq = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cyc(1'b0, 4'd0, 8'd0, 1'b0, 1'b0, 16'h0, 16'h0, "R1 reset state");

        // R2: program pattern bytes
        wr(4'd0, 8'hC3, "R2"); wr(4'd1, 8'hA5, "R2");
        wr(4'd2, 8'h3C, "R2"); wr(4'd3, 8'h5A, "R2");
        wr(4'd4, 8'h0F, "R2"); wr(4'd5, 8'hF0, "R2");
        wr(4'd6, 8'hF0, "R2"); wr(4'd7, 8'h0F, "R2");
        wr(4'd8, 8'h03, "R10 enable");
        wr(4'd9, 8'h00, "R9 initial clear");

        // R2 / R3: in-order stream matches
        for (int k = 0; k < 8; k++) send_pair(k[0], 1'b0, "R2 R3 matching stream");

        // R3: pair-1 data in a pair-0 slot
        smp(1'b0, 16'hF00F, 16'h0FF0, "R3 wrong pair slot");
        check("R7 fail set / R10 irq level");

        // R11: invalid cycle with garbage, then pair 1 still matches
        cyc(1'b0, 4'd0, 8'd0, 1'b0, 1'b1, 16'hFFFF, 16'h1234, "R11 invalid ignored");
        send_pair(1'b1, 1'b0, "R11 phase held");

        wr(4'd9, 8'h00, "R9 clear");

        // R4: frame marker arriving in the pair-1 slot
        send_pair(1'b0, 1'b0, "R4 setup");
        send_pair(1'b0, 1'b1, "R4 frame realigns to pair 0");
        send_pair(1'b1, 1'b0, "R4 pair 1 follows frame");

        // R6: accumulation of single-bit errors
        smp(1'b0, 16'hA5C3, 16'h5A3C ^ 16'h0100, "R6 Q bit error");
        smp(1'b0, 16'hF00F ^ 16'h0002, 16'h0FF0, "R6 I bit accumulates");
        send_pair(1'b0, 1'b0, "R7 stays set");

        // R9: clear coinciding with a mismatch
        cyc(1'b1, 4'd9, 8'h00, 1'b1, 1'b0, 16'h0000, exp_q(m_ph), "R9 clear with mismatch");

        // R10: routing off
        wr(4'd8, 8'h01, "R10 irq masked");

        // R8: detection off
        wr(4'd8, 8'h00, "R8 disable");
        smp(1'b0, 16'h1111, 16'h2222, "R8 ignored");
        smp(1'b1, 16'h3333, 16'h4444, "R8 ignored frame");
        wr(4'd9, 8'h00, "R9 clear while disabled");
        smp(1'b0, 16'h5555, 16'h6666, "R8 ignored after clear");

        // R5: first sample after enable is pair 0
        wr(4'd8, 8'h03, "R5 enable");
        send_pair(1'b0, 1'b0, "R5 first sample pair 0");
        send_pair(1'b1, 1'b0, "R5 then pair 1");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            int unsigned r;
            logic f, p;
            logic [15:0] si, sq;
            r = $urandom_range(0, 99);
            if (r < 3) begin
                wr(4'd9, 8'h00, "R9 random clear");
            end else if (r < 5) begin
                wr(4'd8, 8'($urandom_range(0, 3)), "R8 random ctrl");
            end else if (r < 15) begin
                cyc(1'b0, 4'd0, 8'd0, 1'b0, 1'($urandom_range(0, 1)),
                    16'($urandom), 16'($urandom), "R11 random gap");
            end else begin
                f  = ($urandom_range(0, 9) == 0);
                p  = f ? 1'b0 : m_ph;
                si = exp_i(p); sq = exp_q(p);
                if ($urandom_range(0, 7) == 0) si = si ^ (16'h1 << $urandom_range(0, 15));
                if ($urandom_range(0, 7) == 0) sq = sq ^ (16'h1 << $urandom_range(0, 15));
                smp(f, si, sq, "R6 random stream");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule